// File: doc/BRIEF.md
# Bunch-Synchronous Co-Adding Accumulator

This block sits behind two interleaved ADC channels and turns their sample streams into a per-bunch current measurement. Each clock it takes one sample pair. The pair holds the sample from the even-numbered bunch, taken from the first channel, and the sample from the following odd-numbered bunch, taken from the second channel. A bunch counter tracks where in the revolution the pair falls. A trigger pulse marks the pair that holds bunch 0. Every revolution holds `N_BUNCH` bunches, which is 300 by default, so it lasts `N_BUNCH/2` pair slots.

After a start command the block waits for a trigger. It then co-adds the samples of each bunch over a programmed number of revolutions. The sums live in two block-RAM lanes, one per channel, and are updated by read-modify-write at one pair per clock. When the last revolution completes, the block streams every bunch index with its sum in ascending order over a valid/ready interface that feeds a FIFO. A trigger that arrives in the wrong place re-aligns the counter and raises a sticky flag.

Top module: `coadd_accum`

## Requirements
- R1: While reset is held, and on the first clock after it, `out_valid`, `busy` and `misalign` are 0.
- R2: The pair presented with `trig` high is pair slot 0. Each following pair advances the slot by one. Slot k carries bunch 2k on `adc_even` and bunch 2k+1 on `adc_odd`.
- R3: In the first revolution after an accepted start, each bunch takes its sample as its new value. Nothing from an earlier run remains in it.
- R4: In every later revolution of the run, each bunch's sample is added to its stored sum.
- R5: A run covers `rev_limit` revolutions, from 1 to 1024, and a value of 0 acts as 1. Sums are exact up to 4095 × 1024 in the 22-bit result. Pairs presented during readout are not accumulated.
- R6: After an accepted start, pairs presented before the first trigger are not accumulated, and `busy` stays 1.
- R7: A trigger during accumulation whose preceding pair was not in the last slot sets `misalign`. That trigger's pair becomes slot 0, and counting goes on from there. The flag then holds until the next accepted start, which clears it. A trigger that comes right after the last slot does not set the flag.
- R8: Readout delivers exactly `N_BUNCH` beats, with `out_bunch` running from 0 up to `N_BUNCH`-1, each beat carrying that bunch's sum on `out_sum`.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bunch` and `out_sum` hold steady.
- R10: `busy` is 1 from an accepted start until the clock after the final beat is accepted. A start that arrives while `busy` is 1 has no effect.
- R11: With no trigger, a pair that follows the last slot goes to slot 0 and begins a new revolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| rev_limit | input | 11 | Revolutions per run, latched at start (0 acts as 1) |
| trig | input | 1 | Marks the pair holding bunch 0 |
| adc_even | input | 12 | Sample of the even bunch in this pair |
| adc_odd | input | 12 | Sample of the odd bunch in this pair |
| out_ready | input | 1 | Downstream FIFO can take a beat |
| out_valid | output | 1 | Readout beat present |
| out_bunch | output | 9 | Bunch index of the beat |
| out_sum | output | 22 | Co-added sum of that bunch |
| busy | output | 1 | Run in progress (waiting, accumulating or reading out) |
| misalign | output | 1 | Sticky trigger misalignment flag |

## Verification
A re-aligning trigger can fall on the cycle right after slot 0 has been taken. In that case the read of slot 0 for the new pair happens in the same cycle as the still-pending write of slot 0 from the pair before it. The bench provokes this with two triggers on consecutive cycles at the start of a later revolution. It judges the result by the readout of bunches 0 and 1, which must contain both pairs on top of the earlier revolutions. The same run also checks that `misalign` is set and stays set through readout.

// File: rtl/coadd_pkg.sv
package coadd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_ACC  = 2'd2,
    ST_DUMP = 2'd3
  } acc_state_e;

endpackage

// File: rtl/coadd_slot_track.sv
// Free-running pair-slot counter, re-aligned by the revolution trigger.
module coadd_slot_track #(
  parameter int PAIRS  = 150,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              at_last,
  output logic              early
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PAIRS - 1);

  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    if (trig || slot_q == LAST) cur_slot = '0;
    else                        cur_slot = slot_q + 1'b1;
  end

  assign at_last = (cur_slot == LAST);
  assign early   = trig && (slot_q != LAST);

  always_ff @(posedge clk) begin
    if (rst) slot_q <= LAST;
    else     slot_q <= cur_slot;
  end
endmodule

// File: rtl/coadd_lane.sv
// One accumulator lane: block RAM with a one-cycle read-modify-write.
module coadd_lane #(
  parameter int DEPTH    = 150,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 22
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                first,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [ADDR_W-1:0]   dump_addr,
  output logic [ACC_W-1:0]    rdata
);
  logic [ACC_W-1:0]    mem [DEPTH];
  logic [ADDR_W-1:0]   rd_addr;
  logic                s_v, s_first, fwd_v;
  logic [ADDR_W-1:0]   s_addr, fwd_addr;
  logic [SAMPLE_W-1:0] s_sample;
  logic [ACC_W-1:0]    fwd_data, old_sum, wdata;

  assign rd_addr = take ? addr : dump_addr;

  // A write to the same slot on the previous edge is not yet visible in rdata.
  assign old_sum = (fwd_v && fwd_addr == s_addr) ? fwd_data : rdata;
  assign wdata   = s_first ? ACC_W'(s_sample) : old_sum + ACC_W'(s_sample);

  always_ff @(posedge clk) begin
    rdata <= mem[rd_addr];
    if (s_v) mem[s_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v      <= 1'b0;
      s_first  <= 1'b0;
      s_addr   <= '0;
      s_sample <= '0;
      fwd_v    <= 1'b0;
      fwd_addr <= '0;
      fwd_data <= '0;
    end else begin
      s_v      <= take;
      s_first  <= first;
      s_addr   <= addr;
      s_sample <= sample;
      fwd_v    <= s_v;
      fwd_addr <= s_addr;
      fwd_data <= wdata;
    end
  end
endmodule

// File: rtl/coadd_dump.sv
// Ascending readout of all bunch sums with valid/ready flow control.
module coadd_dump #(
  parameter int N_BUNCH = 300,
  parameter int IDX_W   = 9,
  parameter int ADDR_W  = 8,
  parameter int ACC_W   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              ready,
  input  logic [ACC_W-1:0]  data_even,
  input  logic [ACC_W-1:0]  data_odd,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_bunch,
  output logic [ACC_W-1:0]  out_sum,
  output logic              done
);
  localparam int CNT_W = $clog2(N_BUNCH + 1);

  logic [CNT_W-1:0] idx;
  logic             pend, pend_lane, issue;
  logic [IDX_W-1:0] pend_idx;

  assign rd_addr = ADDR_W'(idx >> 1);
  assign issue   = active && !pend && (!out_valid || ready) && (idx < CNT_W'(N_BUNCH));
  assign done    = out_valid && ready && (out_bunch == IDX_W'(N_BUNCH - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      idx       <= '0;
      pend      <= 1'b0;
      pend_lane <= 1'b0;
      pend_idx  <= '0;
      out_valid <= 1'b0;
      out_bunch <= '0;
      out_sum   <= '0;
    end else begin
      if (pend) begin
        pend      <= 1'b0;
        out_valid <= 1'b1;
        out_bunch <= pend_idx;
        out_sum   <= pend_lane ? data_odd : data_even;
      end else if (out_valid && ready) begin
        out_valid <= 1'b0;
      end
      if (issue) begin
        pend      <= 1'b1;
        pend_lane <= idx[0];
        pend_idx  <= IDX_W'(idx);
        idx       <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/coadd_accum.sv
module coadd_accum
  import coadd_pkg::*;
#(
  parameter int N_BUNCH  = 300,
  parameter int SAMPLE_W = 12,
  parameter int MAX_REVS = 1024,
  localparam int REV_W   = $clog2(MAX_REVS) + 1,
  localparam int ACC_W   = SAMPLE_W + $clog2(MAX_REVS),
  localparam int IDX_W   = $clog2(N_BUNCH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [REV_W-1:0]    rev_limit,
  input  logic                trig,
  input  logic [SAMPLE_W-1:0] adc_even,
  input  logic [SAMPLE_W-1:0] adc_odd,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [IDX_W-1:0]    out_bunch,
  output logic [ACC_W-1:0]    out_sum,
  output logic                busy,
  output logic                misalign
);
  localparam int PAIRS  = N_BUNCH / 2;
  localparam int SLOT_W = $clog2(PAIRS);

  acc_state_e        st;
  logic [REV_W-1:0]  lim_q, rev_q;
  logic              err_q;
  logic [SLOT_W-1:0] cur_slot, dump_addr;
  logic              at_last, early, take, first, rev_end, dump_done;
  logic [SAMPLE_W-1:0] lane_in [2];
  logic [ACC_W-1:0]    lane_rd [2];

  coadd_slot_track #(.PAIRS(PAIRS), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst(rst), .trig(trig),
    .cur_slot(cur_slot), .at_last(at_last), .early(early)
  );

  assign take    = (st == ST_ACC) || (st == ST_ARM && trig);
  assign first   = (rev_q == '0);
  assign rev_end = take && at_last && (REV_W'(rev_q + 1'b1) >= lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      lim_q <= '0;
      rev_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_ARM;
          lim_q <= rev_limit;
          rev_q <= '0;
          err_q <= 1'b0;
        end
        ST_ARM:  if (trig) st <= ST_ACC;
        ST_ACC:  if (early) err_q <= 1'b1;
        ST_DUMP: if (dump_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (take && at_last) rev_q <= rev_q + 1'b1;
      if (rev_end) st <= ST_DUMP;
    end
  end

  assign lane_in[0] = adc_even;
  assign lane_in[1] = adc_odd;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    coadd_lane #(
      .DEPTH(PAIRS), .ADDR_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)
    ) u_lane (
      .clk(clk), .rst(rst), .take(take), .addr(cur_slot), .first(first),
      .sample(lane_in[g]), .dump_addr(dump_addr), .rdata(lane_rd[g])
    );
  end

  coadd_dump #(
    .N_BUNCH(N_BUNCH), .IDX_W(IDX_W), .ADDR_W(SLOT_W), .ACC_W(ACC_W)
  ) u_dump (
    .clk(clk), .rst(rst), .active(st == ST_DUMP), .ready(out_ready),
    .data_even(lane_rd[0]), .data_odd(lane_rd[1]), .rd_addr(dump_addr),
    .out_valid(out_valid), .out_bunch(out_bunch), .out_sum(out_sum),
    .done(dump_done)
  );

  assign busy     = (st != ST_IDLE);
  assign misalign = err_q;
endmodule

// File: rtl/coadd_accum_checker.sv
module coadd_accum_checker #(
  parameter int N_BUNCH = 300,
  parameter int IDX_W   = 9,
  parameter int ACC_W   = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             out_ready,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_bunch,
  input logic [ACC_W-1:0] out_sum,
  input logic             busy,
  input logic             misalign
);
  logic             rst_q;
  logic [IDX_W-1:0] exp_idx;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) exp_idx <= '0;
    else if (out_valid && out_ready)
      exp_idx <= (out_bunch == IDX_W'(N_BUNCH - 1)) ? '0 : exp_idx + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst_q |-> (!out_valid && !busy && !misalign));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bunch) && $stable(out_sum)));

  a_r8_order: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bunch == exp_idx));

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (misalign && !(start && !busy)) |=> misalign);

  a_r10_busy_readout: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_bunch == IDX_W'(N_BUNCH - 1)) |=> !busy);
endmodule

bind coadd_accum coadd_accum_checker #(
  .N_BUNCH(N_BUNCH), .IDX_W(IDX_W), .ACC_W(ACC_W)
) u_coadd_chk (
  .clk(clk), .rst(rst), .start(start), .out_ready(out_ready),
  .out_valid(out_valid), .out_bunch(out_bunch), .out_sum(out_sum),
  .busy(busy), .misalign(misalign)
);

// File: tb/coadd_accum_bench.sv
`timescale 1ns/1ps
module coadd_accum_bench;
  localparam int NB = 300;
  localparam int NP = NB / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [10:0] rev_limit = '0;
  logic        trig = 1'b0;
  logic [11:0] adc_even = '0, adc_odd = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [8:0]  out_bunch;
  logic [21:0] out_sum;
  logic        busy, misalign;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int expv [NB];

  always #2 clk = ~clk;

  coadd_accum u_coadd_accum (
    .clk(clk), .rst(rst), .start(start), .rev_limit(rev_limit), .trig(trig),
    .adc_even(adc_even), .adc_odd(adc_odd), .out_ready(out_ready),
    .out_valid(out_valid), .out_bunch(out_bunch), .out_sum(out_sum),
    .busy(busy), .misalign(misalign)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int val(input int salt, input int rev, input int slot, input int lane);
    if (salt < 0) return 4095;
    return (salt * 977 + rev * 131 + slot * 29 + lane * 1511 + 7) % 4096;
  endfunction

  // One pair per cycle; the model follows R2/R3/R4 for accumulated pairs.
  task automatic feed(input bit tg, input int slot, input int rev, input int salt,
                      input bit first, input bit acc, input bit st);
    int a, b;
    a = val(salt, rev, slot, 0);
    b = val(salt, rev, slot, 1);
    @(negedge clk);
    trig = tg; start = st;
    adc_even = 12'(a); adc_odd = 12'(b);
    if (acc) begin
      if (first) begin expv[2*slot] = a; expv[2*slot+1] = b; end
      else begin expv[2*slot] += a; expv[2*slot+1] += b; end
    end
    @(posedge clk); #1;
  endtask

  task automatic begin_run(input int lim);
    @(negedge clk);
    start = 1'b1; trig = 1'b0; rev_limit = 11'(lim);
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", int'(busy), 1);
    chk(misalign === 1'b0, "R7 cleared by start", int'(misalign), 0);
  endtask

  // Collect all beats; mode 1 applies periodic backpressure (R9).
  task automatic collect(input string tag, input int mode);
    int beat = 0, n = 0, hb = -1, hs = -1;
    bit holding = 0;
    while (beat < NB && n < 6000) begin
      @(negedge clk);
      n++;
      adc_even = 12'(n * 37); adc_odd = 12'(n * 53);
      trig = (n % 41) == 0;
      if (holding) begin
        chk(out_valid === 1'b1 && int'(out_bunch) == hb && int'(out_sum) == hs,
            "R9 hold under backpressure", int'(out_bunch), hb);
        holding = 0;
      end
      out_ready = (mode == 0) ? 1'b1 : ((n % 5) >= 2);
      if (out_valid === 1'b1) begin
        if (out_ready) begin
          chk(int'(out_bunch) == beat, {"R8 order ", tag}, int'(out_bunch), beat);
          chk(int'(out_sum) == expv[beat], {"R4 sum ", tag}, int'(out_sum), expv[beat]);
          beat++;
        end else begin
          holding = 1; hb = int'(out_bunch); hs = int'(out_sum);
        end
      end
    end
    chk(beat == NB, {"R8 beat count ", tag}, beat, NB);
    @(negedge clk);
    trig = 1'b0; out_ready = 1'b1;
    chk(busy === 1'b0 && out_valid === 1'b0, {"R10 idle after readout ", tag}, int'(busy), 0);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R1 out_valid at reset", int'(out_valid), 0);
    chk(busy === 1'b0, "R1 busy at reset", int'(busy), 0);
    chk(misalign === 1'b0, "R1 misalign at reset", int'(misalign), 0);
  endtask

  task automatic t_basic();
    begin_run(4);
    for (int i = 0; i < 10; i++) feed(0, 0, 9, 11, 0, 0, 0);   // R6 ignored
    chk(busy === 1'b1 && out_valid === 1'b0, "R6 waiting for trigger", int'(busy), 1);
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < NP; s++)
        feed(s == 0, s, r, 1, r == 0, 1, (r == 1 && s == 50)); // R10 start ignored
    chk(misalign === 1'b0, "R7 aligned triggers", int'(misalign), 0);
    collect("basic R2", 0);
    chk(misalign === 1'b0, "R7 triggers in readout", int'(misalign), 0);
  endtask

  task automatic t_rerun();
    begin_run(2);
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < NP; s++) feed(s == 0, s, r, 2, r == 0, 1, 0);
    collect("rerun R3", 1);
  endtask

  task automatic t_misalign();
    begin_run(3);
    for (int s = 0; s < NP; s++) feed(s == 0, s, 0, 3, 1, 1, 0);
    for (int s = 0; s < 40; s++) feed(s == 0, s, 1, 3, 0, 1, 0);
    chk(misalign === 1'b0, "R7 no flag before early trigger", int'(misalign), 0);
    feed(1, 0, 7, 3, 0, 1, 0);                 // early trigger resyncs to slot 0
    chk(misalign === 1'b1, "R7 early trigger flagged", int'(misalign), 1);
    for (int s = 1; s < NP; s++) feed(0, s, 1, 3, 0, 1, 0);
    feed(1, 0, 2, 3, 0, 1, 0);                 // aligned
    feed(1, 0, 5, 3, 0, 1, 0);                 // back-to-back: slot 0 again
    for (int s = 1; s < NP; s++) feed(0, s, 2, 3, 0, 1, 0);
    collect("misalign R7", 0);
    chk(misalign === 1'b1, "R7 sticky through readout", int'(misalign), 1);
  endtask

  task automatic t_limit_zero();
    begin_run(0);
    for (int s = 0; s < NP; s++) feed(s == 0, s, 0, 4, 1, 1, 0);
    collect("limit zero R5", 0);
  endtask

  task automatic t_full_scale();
    begin_run(1024);
    for (int r = 0; r < 1024; r++)
      for (int s = 0; s < NP; s++)
        feed(r == 0 && s == 0, s, r, -1, r == 0, 1, 0);   // R11 wrap without trigger
    chk(expv[0] == 4193280, "R5 model full scale", expv[0], 4193280);
    collect("full scale R5 R11", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_rerun();
    t_misalign();
    t_limit_zero();
    t_full_scale();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule